// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block works out the next program counter of a small 8-bit controller core with a 64 KB code space. Each time the core finishes an instruction it raises `step_en`, presents a decoded control-flow class on `jtype`, the instruction bytes, the accumulator, the data pointer and a branch condition. The unit shows the resulting address on `pc_next` in the same cycle and loads it into `pc` at the clock edge.

Several target formats are covered. A signed 8-bit displacement is measured from the following instruction. A full 16-bit address can be given. An 11-bit field can replace the low bits of the following address while its top five bits are kept. An indirect target can be formed from the data pointer plus the accumulator. Calls save the following address on an 8-entry internal return stack and returns take it back. A separate interrupt-busy flag is raised by `irq_start` and cleared by a return-from-interrupt.

Top module: `pc_next_unit`

## Requirements
- R1: After reset `pc` is 0x0000, `irq_busy` is 0 and the return stack is empty.
- R2: When `step_en` is 1, `pc` takes the value of `pc_next` at the clock edge; when `step_en` is 0, `pc` holds. For `jtype`=0 (sequential), and for any code above 8, `pc_next` = `pc` + `ilen`, where `ilen` is 1, 2 or 3.
- R3: For `jtype`=1 (short relative), `pc_next` = `pc` + 2 + sign-extended `op1`.
- R4: For `jtype`=2 (long jump), `pc_next` = {`op1`,`op2`}, with `op1` as the high byte.
- R5: For `jtype`=3 (in-page), `pc_next` = {bits 15:11 of (`pc`+2), `op0[7:5]`, `op1`}. `op0[4]`=0 makes it a jump (first byte xxx00001) and `op0[4]`=1 makes it a call (first byte xxx10001).
- R6: For `jtype`=4 (indirect), `pc_next` = `dptr` + zero-extended `acc`.
- R7: For `jtype`=8 (conditional), with length `ilen` (2 or 3), the offset byte is `op1` when `ilen`=2 and `op2` when `ilen`=3. If `cond`=1 then `pc_next` = `pc` + `ilen` + sign-extended offset, otherwise `pc_next` = `pc` + `ilen`.
- R8: For `jtype`=5 (long call) the address `pc`+3 is pushed and the target is as in R4. For an in-page call the address `pc`+2 is pushed and the target is as in R5.
- R9: For `jtype`=6 (return), `pc_next` is the most recently pushed address that has not yet been popped, and that entry is removed (last in, first out).
- R10: For `jtype`=7 (return-from-interrupt), the behaviour is that of R9 and `irq_busy` is cleared. A pulse on `irq_start` sets `irq_busy` at the next edge. If both occur in the same cycle, `irq_busy` ends up 1.
- R11: A call made with 8 entries already stored raises `stk_err` in that cycle, stores nothing and still goes to its target. A return made with the stack empty raises `stk_err`, leaves the stack unchanged and sets `pc_next` = `pc` + 1.
- R12: All address sums wrap modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | Instruction retires this cycle |
| jtype | input | 4 | Decoded control-flow class (codes in R2 to R10) |
| ilen | input | 2 | Instruction length for sequential and conditional classes |
| op0 | input | 8 | First instruction byte |
| op1 | input | 8 | Second instruction byte |
| op2 | input | 8 | Third instruction byte |
| acc | input | 8 | Accumulator value |
| dptr | input | 16 | Data pointer value |
| cond | input | 1 | Branch condition for the conditional class |
| irq_start | input | 1 | Interrupt service begins |
| pc | output | 16 | Current program counter |
| pc_next | output | 16 | Computed next program counter |
| stk_err | output | 1 | Return stack overflow or underflow this cycle |
| irq_busy | output | 1 | Interrupt in progress |

## Verification
A return-from-interrupt can retire in the same cycle that `irq_start` announces a new interrupt. The flag then sees a clear and a set together, and the stack is popped at the same time. The bench drives this collision on purpose, and also lets random traffic raise `irq_start` at random beside random returns. Each case is judged against a behavioural model in which the set wins, so `irq_busy` must read 1 after the edge while `pc` still follows the popped address.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  localparam int ADDR_W = 16;
  localparam int PAGE_W = 11;

  typedef enum logic [3:0] {
    JT_SEQ   = 4'd0,
    JT_SREL  = 4'd1,
    JT_LONG  = 4'd2,
    JT_PAGE  = 4'd3,
    JT_IND   = 4'd4,
    JT_LCALL = 4'd5,
    JT_RET   = 4'd6,
    JT_RETI  = 4'd7,
    JT_COND  = 4'd8
  } jtype_e;

  typedef logic [ADDR_W-1:0] addr_t;
endpackage

// File: rtl/pcu_target.sv
module pcu_target
  import pcu_pkg::*;
(
  input  addr_t       pc,
  input  jtype_e      jt,
  input  logic [1:0]  ilen,
  input  logic [7:0]  op0,
  input  logic [7:0]  op1,
  input  logic [7:0]  op2,
  input  logic [7:0]  acc,
  input  addr_t       dptr,
  input  logic        cond,
  output addr_t       follow,
  output addr_t       tgt,
  output logic        do_push,
  output logic        do_pop
);
  localparam int HI_W = ADDR_W - PAGE_W;

  addr_t      len;
  logic [7:0] rel;
  addr_t      rel_t;
  addr_t      page_t;
  addr_t      long_t;
  addr_t      ind_t;

  always_comb begin
    unique case (jt)
      JT_SREL, JT_PAGE:           len = addr_t'(2);
      JT_LONG, JT_LCALL:          len = addr_t'(3);
      JT_IND, JT_RET, JT_RETI:    len = addr_t'(1);
      default:                    len = addr_t'(ilen);
    endcase
  end

  assign follow = pc + len;
  assign rel    = (jt == JT_COND && ilen == 2'd3) ? op2 : op1;
  assign rel_t  = follow + {{(ADDR_W-8){rel[7]}}, rel};
  assign page_t = {follow[ADDR_W-1 -: HI_W], op0[7:5], op1};
  assign long_t = {op1, op2};
  assign ind_t  = dptr + addr_t'(acc);

  always_comb begin
    tgt     = follow;
    do_push = 1'b0;
    do_pop  = 1'b0;
    unique case (jt)
      JT_SREL:  tgt = rel_t;
      JT_LONG:  tgt = long_t;
      JT_PAGE: begin
        tgt     = page_t;
        do_push = op0[4];
      end
      JT_IND:   tgt = ind_t;
      JT_LCALL: begin
        tgt     = long_t;
        do_push = 1'b1;
      end
      JT_RET, JT_RETI: do_pop = 1'b1;
      JT_COND:  tgt = cond ? rel_t : follow;
      default:  tgt = follow;
    endcase
  end
endmodule

// File: rtl/pcu_ret_stack.sv
module pcu_ret_stack #(
  parameter int DEPTH = 8,
  parameter int W     = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic                         pop,
  input  logic [W-1:0]                 din,
  output logic [W-1:0]                 dout,
  output logic                         full,
  output logic                         empty,
  output logic [$clog2(DEPTH+1)-1:0]   cnt
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] cnt_d;
  logic [CW-1:0] cnt_m1;
  logic          wr_en;
  logic          rd_en;

  assign full   = (cnt == CW'(DEPTH));
  assign empty  = (cnt == '0);
  assign wr_en  = push && !full;
  assign rd_en  = pop && !empty;
  assign cnt_m1 = cnt - CW'(1);
  assign dout   = empty ? '0 : mem[cnt_m1[IW-1:0]];

  always_comb begin
    cnt_d = cnt;
    if (wr_en)      cnt_d = cnt + CW'(1);
    else if (rd_en) cnt_d = cnt_m1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[cnt[IW-1:0]] <= din;
  end
endmodule

// File: rtl/pcu_irq_flag.sv
module pcu_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic busy
);
  logic busy_d;

  always_comb begin
    busy_d = busy;
    if (clr) busy_d = 1'b0;
    if (set) busy_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy <= 1'b0;
    else        busy <= busy_d;
  end
endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit
  import pcu_pkg::*;
#(
  parameter int STK_DEPTH = 8,
  parameter logic [15:0] RESET_PC = 16'h0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        step_en,
  input  logic [3:0]  jtype,
  input  logic [1:0]  ilen,
  input  logic [7:0]  op0,
  input  logic [7:0]  op1,
  input  logic [7:0]  op2,
  input  logic [7:0]  acc,
  input  logic [15:0] dptr,
  input  logic        cond,
  input  logic        irq_start,
  output logic [15:0] pc,
  output logic [15:0] pc_next,
  output logic        stk_err,
  output logic        irq_busy
);
  localparam int CW = $clog2(STK_DEPTH + 1);

  jtype_e        jt;
  addr_t         follow;
  addr_t         tgt;
  addr_t         stk_top;
  addr_t         pc_d;
  logic          do_push;
  logic          do_pop;
  logic          stk_full;
  logic          stk_empty;
  logic [CW-1:0] stk_cnt;
  logic          reti_en;

  assign jt = jtype_e'(jtype);

  pcu_target u_tgt (
    .pc      (pc),
    .jt      (jt),
    .ilen    (ilen),
    .op0     (op0),
    .op1     (op1),
    .op2     (op2),
    .acc     (acc),
    .dptr    (dptr),
    .cond    (cond),
    .follow  (follow),
    .tgt     (tgt),
    .do_push (do_push),
    .do_pop  (do_pop)
  );

  pcu_ret_stack #(.DEPTH(STK_DEPTH), .W(ADDR_W)) u_stk (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (step_en && do_push),
    .pop   (step_en && do_pop),
    .din   (follow),
    .dout  (stk_top),
    .full  (stk_full),
    .empty (stk_empty),
    .cnt   (stk_cnt)
  );

  assign reti_en = step_en && (jt == JT_RETI);

  pcu_irq_flag u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (irq_start),
    .clr   (reti_en),
    .busy  (irq_busy)
  );

  always_comb begin
    if (do_pop) pc_next = stk_empty ? follow : stk_top;
    else        pc_next = tgt;
  end

  assign stk_err = step_en && ((do_push && stk_full) || (do_pop && stk_empty));

  always_comb begin
    pc_d = pc;
    if (step_en) pc_d = pc_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc <= RESET_PC;
    else        pc <= pc_d;
  end
endmodule

// File: rtl/pcu_chk.sv
module pcu_chk #(
  parameter int STK_DEPTH = 8,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          step_en,
  input logic [3:0]    jtype,
  input logic [7:0]    op0,
  input logic          irq_start,
  input logic [15:0]   pc,
  input logic [15:0]   pc_next,
  input logic          stk_err,
  input logic          irq_busy,
  input logic          stk_full,
  input logic [CW-1:0] stk_cnt
);
  // R2
  hold_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(pc));
  // R2
  adv_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |=> pc == $past(pc_next));
  // R10
  reti_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && jtype == 4'd7 && !irq_start) |=> !irq_busy);
  // R10
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_start |=> irq_busy);
  // R11
  depth_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stk_cnt <= CW'(STK_DEPTH));
  // R11
  ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && stk_full && (jtype == 4'd5 || (jtype == 4'd3 && op0[4]))) |-> stk_err);
  // R11
  ovf_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && stk_full && jtype == 4'd5) |=> $stable(stk_cnt));
  // R9
  pop_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && (jtype == 4'd6 || jtype == 4'd7) && stk_cnt != '0)
      |=> stk_cnt == $past(stk_cnt) - CW'(1));
endmodule

bind pc_next_unit pcu_chk #(.STK_DEPTH(STK_DEPTH), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .step_en   (step_en),
  .jtype     (jtype),
  .op0       (op0),
  .irq_start (irq_start),
  .pc        (pc),
  .pc_next   (pc_next),
  .stk_err   (stk_err),
  .irq_busy  (irq_busy),
  .stk_full  (stk_full),
  .stk_cnt   (stk_cnt)
);

// File: tb/pc_next_unit_tb.sv
module pc_next_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step_en = 1'b0;
  logic [3:0]  jtype = '0;
  logic [1:0]  ilen = 2'd1;
  logic [7:0]  op0 = '0, op1 = '0, op2 = '0, acc = '0;
  logic [15:0] dptr = '0;
  logic        cond = 1'b0;
  logic        irq_start = 1'b0;
  logic [15:0] pc, pc_next;
  logic        stk_err, irq_busy;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  int mpc;
  int mstk[$];
  bit mbusy;

  always #(CLK_PERIOD/2) clk = ~clk;

  pc_next_unit u_dut (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .jtype(jtype), .ilen(ilen),
    .op0(op0), .op1(op1), .op2(op2), .acc(acc), .dptr(dptr), .cond(cond),
    .irq_start(irq_start), .pc(pc), .pc_next(pc_next), .stk_err(stk_err),
    .irq_busy(irq_busy)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int sx(input int b);
    return (b & 8'h80) ? (b | 32'hFFFF_FF00) : b;
  endfunction

  // One cycle: drive at negedge, compare before the edge, update model on it.
  task automatic run(input bit st, input int jt, input int ln, input int b0,
                     input int b1, input int b2, input int a, input int dp,
                     input bit c, input bit irq, input string tag_in);
    int len, fol, nxt, rb;
    bit push, pop, err;
    string tag;
    @(negedge clk);
    step_en = st; jtype = jt[3:0]; ilen = ln[1:0]; op0 = b0[7:0]; op1 = b1[7:0];
    op2 = b2[7:0]; acc = a[7:0]; dptr = dp[15:0]; cond = c; irq_start = irq;
    #1;
    case (jt)
      1, 3: len = 2;
      2, 5: len = 3;
      4, 6, 7: len = 1;
      default: len = ln;
    endcase
    fol = (mpc + len) & 16'hFFFF;
    push = (jt == 5) || (jt == 3 && b0[4]);
    pop = (jt == 6) || (jt == 7);
    rb = (jt == 8 && ln == 3) ? b2 : b1;
    case (jt)
      1: begin nxt = (fol + sx(rb)) & 16'hFFFF; tag = "R3"; end
      2: begin nxt = ((b1 << 8) | b2) & 16'hFFFF; tag = "R4"; end
      3: begin nxt = (fol & 16'hF800) | ((b0 >> 5) << 8) | b1; tag = b0[4] ? "R8" : "R5"; end
      4: begin nxt = (dp + a) & 16'hFFFF; tag = "R6"; end
      5: begin nxt = ((b1 << 8) | b2) & 16'hFFFF; tag = "R8"; end
      6, 7: begin
        nxt = (mstk.size() == 0) ? fol : mstk[$];
        tag = (jt == 7) ? "R10" : "R9";
      end
      8: begin nxt = c ? ((fol + sx(rb)) & 16'hFFFF) : fol; tag = "R7"; end
      default: begin nxt = fol; tag = "R2"; end
    endcase
    err = st && ((push && mstk.size() == DEPTH) || (pop && mstk.size() == 0));
    if (err) tag = "R11";
    if (tag_in != "") tag = tag_in;
    chk(pc == mpc[15:0], "R2", "pc", pc, mpc);
    chk(irq_busy == mbusy, "R10", "irq_busy", irq_busy, mbusy);
    if (st) chk(pc_next == nxt[15:0], tag, "pc_next", pc_next, nxt);
    chk(stk_err == err, err ? "R11" : tag, "stk_err", stk_err, err);
    @(posedge clk);
    if (st) begin
      if (push && mstk.size() < DEPTH) mstk.push_back(fol);
      if (pop && mstk.size() > 0) void'(mstk.pop_back());
      mpc = nxt;
      if (jt == 7) mbusy = 1'b0;
    end
    if (irq) mbusy = 1'b1;
  endtask

  task automatic go(input int jt, input int ln, input int b0, input int b1,
                    input int b2, input string tag);
    run(1'b1, jt, ln, b0, b1, b2, 0, 0, 1'b0, 1'b0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    mpc = 0; mbusy = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: reset state, then an empty-stack return
    #1;
    chk(pc == 16'h0000, "R1", "reset pc", pc, 0);
    chk(irq_busy == 1'b0, "R1", "reset irq_busy", irq_busy, 0);
    go(6, 1, 0, 0, 0, "R1");
    // R2 sequential lengths and hold
    go(0, 1, 0, 0, 0, "R2");
    go(0, 2, 0, 0, 0, "R2");
    go(0, 3, 0, 0, 0, "R2");
    run(1'b0, 2, 0, 0, 8'h55, 8'h66, 0, 0, 1'b0, 1'b0, "R2");
    go(0, 3, 0, 0, 0, "R2");
    // R3 forward and backward
    go(1, 0, 0, 8'h10, 0, "R3");
    go(1, 0, 0, 8'hF0, 0, "R3");
    go(1, 0, 0, 8'h80, 0, "R3");
    // R4 and R12 wrap on sequential step
    go(2, 0, 0, 8'hFF, 8'hFE, "R4");
    go(0, 3, 0, 0, 0, "R12");
    go(1, 0, 0, 8'hF0, 0, "R12");
    // R5 near page boundary: following address crosses into next 2K block
    go(2, 0, 0, 8'h07, 8'hFE, "R4");
    go(3, 0, 8'hA1, 8'h34, 0, "R5");
    go(3, 0, 8'h01, 8'h00, 0, "R5");
    // R6 indirect with wrap
    run(1'b1, 4, 0, 0, 0, 0, 8'h20, 16'hFFF0, 1'b0, 1'b0, "R6");
    run(1'b1, 4, 0, 0, 0, 0, 8'h04, 16'h1200, 1'b0, 1'b0, "R6");
    // R7 conditional, both lengths, both conditions
    run(1'b1, 8, 2, 0, 8'h08, 8'h77, 0, 0, 1'b1, 1'b0, "R7");
    run(1'b1, 8, 3, 0, 8'h77, 8'hFC, 0, 0, 1'b1, 1'b0, "R7");
    run(1'b1, 8, 3, 0, 8'h77, 8'hFC, 0, 0, 1'b0, 1'b0, "R7");
    run(1'b1, 8, 2, 0, 8'h40, 0, 0, 0, 1'b0, 1'b0, "R7");
    // R8 fill stack with mixed calls, R11 overflow, R9 unwind, R11 underflow
    for (int i = 0; i < DEPTH; i++) begin
      if (i[0]) go(3, 0, 8'h51, i * 8, 0, "R8");
      else      go(5, 0, 0, 8'h30 + i, 8'h10 * i, "R8");
    end
    go(5, 0, 0, 8'hAB, 8'hCD, "R11");
    go(3, 0, 8'h31, 8'h22, 0, "R11");
    for (int i = 0; i < DEPTH; i++) go(6, 0, 0, 0, 0, "R9");
    go(6, 0, 0, 0, 0, "R11");
    go(7, 0, 0, 0, 0, "R11");
    // R10 interrupt flag
    go(5, 0, 0, 8'h12, 8'h34, "R8");
    run(1'b0, 0, 1, 0, 0, 0, 0, 0, 1'b0, 1'b1, "R10");
    go(7, 0, 0, 0, 0, "R10");
    go(0, 1, 0, 0, 0, "R10");
    go(5, 0, 0, 8'h56, 8'h78, "R8");
    run(1'b0, 0, 1, 0, 0, 0, 0, 0, 1'b0, 1'b1, "R10");
    run(1'b1, 7, 0, 0, 0, 0, 0, 0, 1'b0, 1'b1, "R10");
    go(0, 1, 0, 0, 0, "R10");
    go(7, 0, 0, 0, 0, "R10");
    // random traffic
    for (int i = 0; i < 600; i++) begin
      int jt;
      jt = $urandom_range(0, 10);
      if (jt > 8 && i[0]) jt = 6;
      run($urandom_range(0, 7) != 0, jt, $urandom_range(1, 3), $urandom_range(0, 255),
          $urandom_range(0, 255), $urandom_range(0, 255), $urandom_range(0, 255),
          $urandom_range(0, 65535), $urandom_range(0, 1) == 1,
          $urandom_range(0, 9) == 0, "");
    end
    @(negedge clk);
    #1;
    chk(pc == mpc[15:0], "R2", "final pc", pc, mpc);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule